// File: doc/BRIEF.md
# Branch Next-Address and Link Unit

This unit works out where instruction fetch goes next in a machine with 32-bit instruction words and byte addresses that are word aligned. On each cycle it receives the address of the current instruction, the instruction word itself and a taken flag, and it produces the next fetch address combinationally. The taken flag comes from condition logic outside the unit.

Four kinds of target are possible:
- a displacement taken from a 24-bit field;
- a displacement taken from a 14-bit field;
- the link register;
- the count register.

Either displacement can be used on its own as an absolute address, or added to the address of the branch.

The unit also holds the link register and the count register. A branch that has its link bit set writes the return address into the link register at the clock edge. Software can write both registers through dedicated write ports.

The unit works in a 64-bit mode and in a 32-bit mode. In 32-bit mode only the low word of every address it produces is kept.

Top module: `branch_next_addr`

## Requirements
- R1: Opcode 18 in `instr[31:26]` is the immediate form and always redirects, whatever `taken` is. Its displacement is `instr[25:2]` with two zero bits appended below and then sign-extended.
- R2: Opcode 16 is the conditional form. Its displacement is `instr[15:2]` with two zero bits appended below and then sign-extended. It redirects only when `taken` is 1.
- R3: For opcodes 16 and 18, `instr[1]` selects how the displacement is used. When `instr[1]` is 0, the target is the displacement added to `cur_addr`. When `instr[1]` is 1, the target is the displacement itself.
- R4: Opcode 19 with the value 16 in `instr[10:1]` branches to the link register. Opcode 19 with the value 528 in `instr[10:1]` branches to the count register. Both redirect only when `taken` is 1, and the two low bits of the target are forced to 0.
- R5: In all other cases `next_addr` is `cur_addr + 4`. This covers a form that is not taken, any other opcode, and opcode 19 with any other value in `instr[10:1]`.
- R6: All address sums wrap modulo 2^64.
- R7: When `mode64` is 0, bits 63:32 of `next_addr` are 0, and bits 63:32 of any return address that a branch writes are also 0.
- R8: `instr[0]` is the link bit. When it is 1 on any of the four branch forms, taken or not, `link_q` becomes `cur_addr + 4` at the next clock edge. `link_q` does not change when the link bit is 0, and it does not change on an instruction that is not a branch.
- R9: When a branch to the link register also has its link bit set, its target is the value `link_q` held before the edge that writes the new return address.
- R10: A software write takes effect at the next clock edge: `lr_wr_data` goes to `link_q` and `ctr_wr_data` goes to `count_q`. If a link update from a branch falls in the same cycle as a software link write, the branch update wins.
- R11: Reset is asynchronous and active low. It clears both `link_q` and `count_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode64 | input | 1 | 1 selects 64-bit addressing, 0 selects 32-bit addressing |
| cur_addr | input | 64 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| taken | input | 1 | Branch condition for the conditional and register forms |
| lr_wr_en | input | 1 | Software write enable for the link register |
| lr_wr_data | input | 64 | Software write data for the link register |
| ctr_wr_en | input | 1 | Software write enable for the count register |
| ctr_wr_data | input | 64 | Software write data for the count register |
| next_addr | output | 64 | Next fetch address |
| link_q | output | 64 | Current link register value |
| count_q | output | 64 | Current count register value |

## Verification
Two functions of this unit can fall in the same cycle: the return-address write from a branch with its link bit set, and a software write to the link register. The bench provokes this by asserting `lr_wr_en` together with a conditional branch that has its link bit set and is not taken. It then judges the outcome after the edge: `link_q` must hold the branch's return address and not `lr_wr_data`.

A second overlap is a branch to the link register that also has its link bit set. Here the bench checks two things. In that same cycle, `next_addr` must come from the old link value. After the edge, `link_q` must hold the new return address.

// File: rtl/branch_next_addr.sv
module branch_next_addr #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode64,
  input  logic [AW-1:0] cur_addr,
  input  logic [31:0]   instr,
  input  logic          taken,
  input  logic          lr_wr_en,
  input  logic [AW-1:0] lr_wr_data,
  input  logic          ctr_wr_en,
  input  logic [AW-1:0] ctr_wr_data,
  output logic [AW-1:0] next_addr,
  output logic [AW-1:0] link_q,
  output logic [AW-1:0] count_q
);
  localparam logic [5:0] OP_IMM  = 6'd18;
  localparam logic [5:0] OP_COND = 6'd16;
  localparam logic [5:0] OP_REG  = 6'd19;
  localparam logic [9:0] XO_LINK = 10'd16;
  localparam logic [9:0] XO_CNT  = 10'd528;
  localparam int         NARROW  = 32;

  logic [5:0]    opc;
  logic [9:0]    xo;
  logic          abs_sel, lk_bit;
  logic          is_imm, is_cond, is_to_lr, is_to_ctr, is_branch;
  logic          redirect;
  logic [AW-1:0] li_ext, bd_ext, disp, rel_tgt, ind_tgt, seq_addr, raw_next, mask;

  assign opc     = instr[31:26];
  assign xo      = instr[10:1];
  assign abs_sel = instr[1];
  assign lk_bit  = instr[0];

  assign is_imm    = (opc == OP_IMM);
  assign is_cond   = (opc == OP_COND);
  assign is_to_lr  = (opc == OP_REG) && (xo == XO_LINK);
  assign is_to_ctr = (opc == OP_REG) && (xo == XO_CNT);
  assign is_branch = is_imm | is_cond | is_to_lr | is_to_ctr;

  assign li_ext = {{(AW-26){instr[25]}}, instr[25:2], 2'b00};
  assign bd_ext = {{(AW-16){instr[15]}}, instr[15:2], 2'b00};
  assign disp   = is_imm ? li_ext : bd_ext;

  assign rel_tgt  = abs_sel ? disp : cur_addr + disp;
  assign ind_tgt  = is_to_lr ? {link_q[AW-1:2], 2'b00} : {count_q[AW-1:2], 2'b00};
  assign seq_addr = cur_addr + AW'(4);

  assign redirect = is_imm | ((is_cond | is_to_lr | is_to_ctr) & taken);
  assign raw_next = !redirect ? seq_addr : ((is_imm | is_cond) ? rel_tgt : ind_tgt);

  assign mask      = mode64 ? {AW{1'b1}} : {{(AW-NARROW){1'b0}}, {NARROW{1'b1}}};
  assign next_addr = raw_next & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q  <= '0;
      count_q <= '0;
    end else begin
      if (is_branch && lk_bit) link_q <= seq_addr & mask;
      else if (lr_wr_en)       link_q <= lr_wr_data;
      if (ctr_wr_en)           count_q <= ctr_wr_data;
    end
  end
endmodule

// File: rtl/branch_next_addr_chk.sv
module branch_next_addr_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode64,
  input logic [AW-1:0] cur_addr,
  input logic [31:0]   instr,
  input logic          taken,
  input logic          lr_wr_en,
  input logic [AW-1:0] lr_wr_data,
  input logic          ctr_wr_en,
  input logic [AW-1:0] ctr_wr_data,
  input logic [AW-1:0] next_addr,
  input logic [AW-1:0] link_q,
  input logic [AW-1:0] count_q
);
  logic          c_link_br, c_cond;
  logic [AW-1:0] c_ret;

  assign c_cond    = (instr[31:26] == 6'd16);
  assign c_link_br = instr[0] && ((instr[31:26] == 6'd18) || c_cond ||
                     ((instr[31:26] == 6'd19) && ((instr[10:1] == 10'd16) || (instr[10:1] == 10'd528))));
  assign c_ret     = mode64 ? cur_addr + AW'(4) : {{(AW-32){1'b0}}, cur_addr[31:0] + 32'd4};

  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_addr[1:0] == 2'b00) |-> (next_addr[1:0] == 2'b00)); // R1
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !mode64 |-> (next_addr[AW-1:32] == '0)); // R7
  AST_NOTAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cond && !taken) |-> (next_addr == c_ret)); // R5
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_link_br && !lr_wr_en) |=> $stable(link_q)); // R8
  AST_LINK_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    c_link_br |=> (link_q == $past(c_ret))); // R10
  AST_LINK_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_link_br && lr_wr_en) |=> (link_q == $past(lr_wr_data))); // R10
  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr_en |=> (count_q == $past(ctr_wr_data))); // R10
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_wr_en |=> $stable(count_q)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (link_q == '0 && count_q == '0)); // R11
endmodule

bind branch_next_addr branch_next_addr_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_branch_next_addr.sv
module tb_branch_next_addr;
  logic        clk = 0, rst_n = 0, mode64 = 1, taken = 0;
  logic [63:0] cur_addr = '0, lr_wr_data = '0, ctr_wr_data = '0;
  logic [31:0] instr = '0;
  logic        lr_wr_en = 0, ctr_wr_en = 0;
  logic [63:0] next_addr, link_q, count_q;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  branch_next_addr dut (.*);

  function automatic logic [31:0] enc_i(logic [23:0] li, logic aa, logic lk);
    return {6'd18, li, aa, lk};
  endfunction
  function automatic logic [31:0] enc_b(logic [13:0] bd, logic aa, logic lk);
    return {6'd16, 5'd12, 5'd0, bd, aa, lk};
  endfunction
  function automatic logic [31:0] enc_x(logic [9:0] xo, logic lk);
    return {6'd19, 5'd20, 5'd0, 5'd0, xo, lk};
  endfunction

  localparam logic [31:0] NOP = {6'd14, 26'd0};

  typedef struct packed {
    logic        m64;
    logic        tk;
    logic [31:0] ins;
    logic [63:0] cur;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, enc_i(24'h000010, 1'b0, 1'b0), 64'h1000, 64'h1040},
    '{1'b1, 1'b0, enc_i(24'hFFFFFC, 1'b0, 1'b0), 64'h1000, 64'h0FF0},
    '{1'b1, 1'b0, enc_i(24'h000100, 1'b1, 1'b0), 64'h1000, 64'h0400},
    '{1'b1, 1'b0, enc_i(24'h800000, 1'b1, 1'b0), 64'h1000, 64'hFFFF_FFFF_FE00_0000},
    '{1'b1, 1'b1, enc_b(14'h0008, 1'b0, 1'b0),  64'h2000, 64'h2020},
    '{1'b1, 1'b0, enc_b(14'h0008, 1'b0, 1'b0),  64'h2000, 64'h2004},
    '{1'b1, 1'b1, enc_b(14'h3FFF, 1'b0, 1'b0),  64'h2000, 64'h1FFC},
    '{1'b1, 1'b1, enc_b(14'h2000, 1'b1, 1'b0),  64'h2000, 64'hFFFF_FFFF_FFFF_8000},
    '{1'b1, 1'b1, enc_x(10'd16, 1'b0),          64'h3000, 64'h1234_5674},
    '{1'b1, 1'b1, enc_x(10'd528, 1'b0),         64'h3000, 64'hFFFF_FFFF_8000_0000},
    '{1'b1, 1'b0, enc_x(10'd528, 1'b0),         64'h3000, 64'h3004},
    '{1'b1, 1'b1, NOP,                          64'h3000, 64'h3004},
    '{1'b1, 1'b1, enc_x(10'd0, 1'b0),           64'h3000, 64'h3004},
    '{1'b1, 1'b0, NOP,                          64'hFFFF_FFFF_FFFF_FFFC, 64'h0},
    '{1'b0, 1'b0, NOP,                          64'h0000_0000_FFFF_FFFC, 64'h0},
    '{1'b0, 1'b0, enc_i(24'h800000, 1'b1, 1'b0), 64'h1000, 64'h0000_0000_FE00_0000},
    '{1'b0, 1'b1, enc_x(10'd528, 1'b0),         64'h3000, 64'h0000_0000_8000_0000},
    '{1'b0, 1'b0, enc_i(24'h000004, 1'b0, 1'b0), 64'h12_FFFF_FFF8, 64'h8}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:          return "R1";
      2, 3:          return "R3";
      4, 5, 6:       return "R2";
      7:             return "R3";
      8, 9:          return "R4";
      10, 11, 12:    return "R5";
      13:            return "R6";
      default:       return "R7";
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    instr = NOP; taken = 0; lr_wr_en = 0; ctr_wr_en = 0; mode64 = 1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    instr = NOP;
    repeat (2) @(posedge clk);
    #1;
    check("R11", "link after reset", link_q, 64'h0);
    check("R11", "count after reset", count_q, 64'h0);
    @(negedge clk) rst_n = 1;

    @(negedge clk);
    lr_wr_en = 1;  lr_wr_data = 64'h1234_5677;
    ctr_wr_en = 1; ctr_wr_data = 64'hFFFF_FFFF_8000_0002;
    @(posedge clk); #1;
    check("R10", "link sw write", link_q, 64'h1234_5677);
    check("R10", "count sw write", count_q, 64'hFFFF_FFFF_8000_0002);
    idle();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode64 = VECS[i].m64; taken = VECS[i].tk;
      instr = VECS[i].ins;  cur_addr = VECS[i].cur;
      #1 check(req_of(i), $sformatf("vector %0d next_addr", i), next_addr, VECS[i].exp);
    end
    @(posedge clk); #1;
    check("R8", "link held with link bit clear", link_q, 64'h1234_5677);
    idle();

    // R8: immediate branch with link bit
    @(negedge clk);
    cur_addr = 64'h5000; instr = enc_i(24'h000010, 1'b0, 1'b1);
    #1 check("R1", "link-form next_addr", next_addr, 64'h5040);
    @(posedge clk); #1;
    check("R8", "link after immediate branch-and-link", link_q, 64'h5004);
    idle();

    // R10: branch update wins over software write; not-taken still links
    @(negedge clk);
    cur_addr = 64'h6000; instr = enc_b(14'h0008, 1'b0, 1'b1); taken = 0;
    lr_wr_en = 1; lr_wr_data = 64'hAAAA;
    #1 check("R5", "not-taken link-form next_addr", next_addr, 64'h6004);
    @(posedge clk); #1;
    check("R10", "branch update beats sw write", link_q, 64'h6004);
    idle();

    // R8: bit 0 on a non-branch has no link effect
    @(negedge clk);
    instr = {6'd14, 25'd0, 1'b1}; lr_wr_en = 1; lr_wr_data = 64'h4444;
    @(posedge clk); #1;
    check("R8", "non-branch with bit0 lets sw write through", link_q, 64'h4444);
    @(negedge clk);
    lr_wr_en = 0;
    @(posedge clk); #1;
    check("R8", "non-branch with bit0 leaves link", link_q, 64'h4444);
    idle();

    // R9: indirect to link with link bit reads old value
    @(negedge clk);
    lr_wr_en = 1; lr_wr_data = 64'h7003;
    @(negedge clk);
    lr_wr_en = 0; cur_addr = 64'h9000; instr = enc_x(10'd16, 1'b1); taken = 1;
    #1 check("R9", "target from old link", next_addr, 64'h7000);
    @(posedge clk); #1;
    check("R9", "link after indirect branch-and-link", link_q, 64'h9004);
    idle();

    // R7: 32-bit mode wraps target and return address
    @(negedge clk);
    mode64 = 0; cur_addr = 64'h1_FFFF_FFFC; instr = enc_i(24'h000010, 1'b0, 1'b1);
    #1 check("R7", "narrow relative target", next_addr, 64'h3C);
    @(posedge clk); #1;
    check("R7", "narrow return address", link_q, 64'h0);
    idle();

    // R10: count write
    @(negedge clk);
    ctr_wr_en = 1; ctr_wr_data = 64'h0000_0000_0000_0ABF;
    @(posedge clk); #1;
    check("R10", "count second write", count_q, 64'hABF);
    idle();
    @(negedge clk);
    instr = enc_x(10'd528, 1'b0); taken = 1; cur_addr = 64'h100;
    #1 check("R4", "count target low bits cleared", next_addr, 64'hABC);
    idle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule